// File: doc/BRIEF.md
# VCO Preset Calibration Sequencer

This controller runs the start-up calibration of a frequency-presetting PLL, then watches the loop once it is running. It leaves reset in calibration mode. The main loop is held open and the VCO tuning input is pinned to mid-supply. The controller then walks the VCO through a grid of preset settings. There are four coarse band settings, and within each band a set of evenly spaced fine codes. For every setting it waits a programmable number of reference periods so the oscillator can settle. It then counts divided VCO edges over a programmable window of reference periods and writes that count into a calibration table. An interpolation stage elsewhere turns the table into preset curves.

After the last table write the controller closes the loop and moves to operation mode. There it drives a lock-state flag that keeps the auxiliary leakage-compensation loop cleared while the synthesizer is settling. The flag is released only after a programmable run of reference periods in which both phase-detector outputs stay narrow. A request for a new divide ratio raises the flag again, and the lock search starts over. The analog parts are seen only as strobes: one reference tick per reference period, one edge strobe per divided VCO edge, and the two phase-detector levels.

Top module: `pll_cal_sequencer`

## Requirements
- R1: In the cycle after reset is released, the outputs are loop_closed=0, bias_mid=1, ls=1, cal_done=0, tbl_we=0, p_code=0 and c_code=0. Calibration always comes before operation.
- R2: The sweep makes 32 measurements. The point index runs 0..7 in the inner loop and the band index runs 0..3 in the outer loop. c_code equals point index × 18, which is floor(127/(NPTS-1)). p_code is the thermometer code of the band index: 000, 001, 011, 111.
- R3: Each measurement ends in exactly one cycle with tbl_we=1. In that cycle tbl_addr = {band index in bits 4:3, point index in bits 2:0} and tbl_data is the measured count.
- R4: After each code change the block waits settle_refs ref_tick strobes (a value of 0 acts as 1). It then counts vco_edge strobes from the cycle after the last settle tick up to and including the cycle of the win_refs-th tick that follows (0 acts as 1). The count saturates at all ones, and the codes do not change inside the window.
- R5: cal_done is high for exactly one cycle, the cycle after the final table write. From that cycle on, loop_closed=1 and bias_mid=0, and they stay that way until reset.
- R6: ls stays at 1 for the whole calibration and in operation until lock is declared.
- R7: In operation, a period runs from the cycle after one ref_tick through the next ref_tick. The first period starts in the cal_done cycle. A period is good when neither pfd_up nor pfd_dn stays high for pulse_thr consecutive cycles. ls falls in the cycle after the tick that completes lock_refs consecutive good periods (0 acts as 1). A period that is not good restarts the run.
- R8: Once ls is 0, later wide phase-detector pulses leave it at 0.
- R9: A ratio_req strobe sets ls to 1 in the next cycle and restarts the count of good periods from zero.
- R10: A reset given during operation opens the loop again and repeats the full sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle strobe per reference period |
| vco_edge | input | 1 | One-cycle strobe per divided VCO edge |
| pfd_up | input | 1 | Main phase-detector up level |
| pfd_dn | input | 1 | Main phase-detector down level |
| ratio_req | input | 1 | Strobe: a new divide ratio was requested |
| settle_refs | input | 8 | Reference periods of settle wait per code step |
| win_refs | input | 8 | Reference periods in the counting window |
| lock_refs | input | 8 | Consecutive good periods needed for lock |
| pulse_thr | input | 6 | Pulse width, in cycles, that marks a period as not good |
| loop_closed | output | 1 | Main loop switch closed |
| bias_mid | output | 1 | Force VCO tuning input to mid-supply |
| p_code | output | 3 | Band preset code |
| c_code | output | 7 | Fine preset code |
| tbl_we | output | 1 | Calibration table write strobe |
| tbl_addr | output | 5 | Table address {band, point} |
| tbl_data | output | 16 | Measured edge count |
| cal_done | output | 1 | One-cycle end-of-sweep pulse |
| ls | output | 1 | Lock-state flag, high while the loop is settling |

## Verification
Some properties are checked on every cycle. These cover the one-cycle width of the write strobe and the done pulse, and the loop switch never reopening without a reset. They also cover codes and the edge counter holding still outside their windows, ls staying high until the loop closes, ls falling only on a reference tick, and a ratio request raising ls. The bench scenarios are needed for the rest. They show the write order, the code values and the exact counts, which prove that settle-time edges are excluded. They also show that a single wide pulse restarts the lock run, that a zero settle length acts as one, and that a mid-operation reset repeats the sweep.

// File: rtl/pllcal_pkg.sv
package pllcal_pkg;

    localparam int BAND_W     = 3;
    localparam int BAND_IDX_W = 2;
    localparam int NUM_BANDS  = 1 << BAND_IDX_W;

    typedef enum logic [2:0] {
        ST_SETTLE = 3'd0,
        ST_COUNT  = 3'd1,
        ST_WRITE  = 3'd2,
        ST_DONE   = 3'd3,
        ST_OPER   = 3'd4
    } cal_state_e;

    // Band index to thermometer-coded band setting: 0->000, 1->001, 2->011, 3->111
    function automatic logic [BAND_W-1:0] band_code(input logic [BAND_IDX_W-1:0] idx);
        logic [BAND_W:0] oh;
        oh      = '0;
        oh[idx] = 1'b1;
        return BAND_W'(oh - 1'b1);
    endfunction

endpackage

// File: rtl/cal_sweep_fsm.sv
module cal_sweep_fsm
    import pllcal_pkg::*;
#(
    parameter int NPTS  = 8,
    parameter int CFG_W = 8,
    localparam int PT_W = $clog2(NPTS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ref_tick,
    input  logic [CFG_W-1:0]      settle_refs,
    input  logic [CFG_W-1:0]      win_refs,
    output cal_state_e            state,
    output logic [PT_W-1:0]       pt_idx,
    output logic [BAND_IDX_W-1:0] band_idx
);

    logic [CFG_W-1:0] ref_cnt;
    logic [CFG_W:0]   ref_next;
    logic             settle_hit;
    logic             win_hit;
    logic             last_pt;
    logic             last_point;

    assign ref_next   = {1'b0, ref_cnt} + (CFG_W+1)'(1);
    assign settle_hit = ref_next >= {1'b0, settle_refs};
    assign win_hit    = ref_next >= {1'b0, win_refs};
    assign last_pt    = pt_idx == PT_W'(NPTS-1);
    assign last_point = last_pt && (band_idx == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_SETTLE;
            ref_cnt  <= '0;
            pt_idx   <= '0;
            band_idx <= '0;
        end else begin
            case (state)
                ST_SETTLE: if (ref_tick) begin
                    if (settle_hit) begin
                        state   <= ST_COUNT;
                        ref_cnt <= '0;
                    end else begin
                        ref_cnt <= ref_next[CFG_W-1:0];
                    end
                end
                ST_COUNT: if (ref_tick) begin
                    if (win_hit) begin
                        state   <= ST_WRITE;
                        ref_cnt <= '0;
                    end else begin
                        ref_cnt <= ref_next[CFG_W-1:0];
                    end
                end
                ST_WRITE: begin
                    state <= last_point ? ST_DONE : ST_SETTLE;
                    if (!last_point) begin
                        if (last_pt) begin
                            pt_idx   <= '0;
                            band_idx <= band_idx + BAND_IDX_W'(1);
                        end else begin
                            pt_idx   <= pt_idx + PT_W'(1);
                        end
                    end
                end
                ST_DONE:  state <= ST_OPER;
                default:  state <= ST_OPER;
            endcase
        end
    end

    AST_CODES_HOLD_IN_WINDOW: assert property (@(posedge clk) disable iff (rst) (state == ST_COUNT) |=> (pt_idx == $past(pt_idx) && band_idx == $past(band_idx))); // R4
    AST_SWEEP_RESUMES: assert property (@(posedge clk) disable iff (rst) (state == ST_WRITE && !last_point) |=> (state == ST_SETTLE)); // R2

endmodule

// File: rtl/cal_freq_counter.sv
module cal_freq_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             vco_edge,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (en && vco_edge && (count != '1)) begin
            count <= count + CNT_W'(1);
        end
    end

    AST_COUNT_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst) (!en && !clr) |=> (count == $past(count))); // R4
    AST_COUNT_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (rst) (en && !clr) |=> (count == $past(count) || count == $past(count) + CNT_W'(1))); // R4

endmodule

// File: rtl/cal_lock_monitor.sv
module cal_lock_monitor #(
    parameter int CFG_W = 8,
    parameter int THR_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             ref_tick,
    input  logic             pfd_up,
    input  logic             pfd_dn,
    input  logic             ratio_req,
    input  logic [THR_W-1:0] pulse_thr,
    input  logic [CFG_W-1:0] lock_refs,
    output logic             ls
);

    logic [THR_W-1:0] up_run, dn_run, up_next, dn_next;
    logic             wide_now;
    logic             bad_seen;
    logic [CFG_W-1:0] good_cnt;
    logic [CFG_W:0]   good_next;
    logic             lock_hit;

    assign up_next   = !pfd_up ? '0 : ((up_run == '1) ? up_run : up_run + THR_W'(1));
    assign dn_next   = !pfd_dn ? '0 : ((dn_run == '1) ? dn_run : dn_run + THR_W'(1));
    assign wide_now  = (pfd_up && (up_next >= pulse_thr)) || (pfd_dn && (dn_next >= pulse_thr));
    assign good_next = {1'b0, good_cnt} + (CFG_W+1)'(1);
    assign lock_hit  = good_next >= {1'b0, lock_refs};

    always_ff @(posedge clk) begin
        if (rst || !active || ratio_req) begin
            ls       <= 1'b1;
            good_cnt <= '0;
            bad_seen <= 1'b0;
            up_run   <= '0;
            dn_run   <= '0;
        end else begin
            up_run <= up_next;
            dn_run <= dn_next;
            if (ref_tick) begin
                bad_seen <= 1'b0;
                if (bad_seen || wide_now) begin
                    good_cnt <= '0;
                end else if (lock_hit) begin
                    ls <= 1'b0;
                end else begin
                    good_cnt <= good_next[CFG_W-1:0];
                end
            end else if (wide_now) begin
                bad_seen <= 1'b1;
            end
        end
    end

    AST_LS_FALLS_ON_TICK: assert property (@(posedge clk) disable iff (rst) $fell(ls) |-> $past(ref_tick)); // R7
    AST_RATIO_RELOCK: assert property (@(posedge clk) disable iff (rst) ratio_req |=> ls); // R9
    AST_LS_HIGH_INACTIVE: assert property (@(posedge clk) disable iff (rst) !active |=> ls); // R6

endmodule

// File: rtl/pll_cal_sequencer.sv
module pll_cal_sequencer
    import pllcal_pkg::*;
#(
    parameter int NPTS   = 8,
    parameter int CODE_W = 7,
    parameter int CNT_W  = 16,
    parameter int CFG_W  = 8,
    parameter int THR_W  = 6,
    localparam int PT_W   = $clog2(NPTS),
    localparam int ADDR_W = BAND_IDX_W + PT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic              vco_edge,
    input  logic              pfd_up,
    input  logic              pfd_dn,
    input  logic              ratio_req,
    input  logic [CFG_W-1:0]  settle_refs,
    input  logic [CFG_W-1:0]  win_refs,
    input  logic [CFG_W-1:0]  lock_refs,
    input  logic [THR_W-1:0]  pulse_thr,
    output logic              loop_closed,
    output logic              bias_mid,
    output logic [BAND_W-1:0] p_code,
    output logic [CODE_W-1:0] c_code,
    output logic              tbl_we,
    output logic [ADDR_W-1:0] tbl_addr,
    output logic [CNT_W-1:0]  tbl_data,
    output logic              cal_done,
    output logic              ls
);

    localparam int C_STEP = ((1 << CODE_W) - 1) / (NPTS - 1);

    cal_state_e            state;
    logic [PT_W-1:0]       pt_idx;
    logic [BAND_IDX_W-1:0] band_idx;
    logic [CNT_W-1:0]      edge_count;

    cal_sweep_fsm #(.NPTS(NPTS), .CFG_W(CFG_W)) u_sweep (
        .clk(clk), .rst(rst), .ref_tick(ref_tick),
        .settle_refs(settle_refs), .win_refs(win_refs),
        .state(state), .pt_idx(pt_idx), .band_idx(band_idx)
    );

    cal_freq_counter #(.CNT_W(CNT_W)) u_meter (
        .clk(clk), .rst(rst),
        .clr(state == ST_SETTLE), .en(state == ST_COUNT),
        .vco_edge(vco_edge), .count(edge_count)
    );

    cal_lock_monitor #(.CFG_W(CFG_W), .THR_W(THR_W)) u_lock (
        .clk(clk), .rst(rst), .active(loop_closed), .ref_tick(ref_tick),
        .pfd_up(pfd_up), .pfd_dn(pfd_dn), .ratio_req(ratio_req),
        .pulse_thr(pulse_thr), .lock_refs(lock_refs), .ls(ls)
    );

    assign loop_closed = (state == ST_DONE) || (state == ST_OPER);
    assign bias_mid    = !loop_closed;
    assign cal_done    = state == ST_DONE;
    assign tbl_we      = state == ST_WRITE;
    assign tbl_addr    = {band_idx, pt_idx};
    assign tbl_data    = edge_count;
    assign p_code      = band_code(band_idx);
    assign c_code      = CODE_W'(pt_idx) * CODE_W'(C_STEP);

    AST_WRITE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst) tbl_we |=> !tbl_we); // R3
    AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst) cal_done |=> (!cal_done && loop_closed)); // R5
    AST_LOOP_STAYS_CLOSED: assert property (@(posedge clk) disable iff (rst) loop_closed |=> loop_closed); // R5
    AST_LS_HIGH_IN_CAL: assert property (@(posedge clk) disable iff (rst) !loop_closed |-> ls); // R6

endmodule

// File: tb/pll_cal_sequencer_tb.sv
module pll_cal_sequencer_tb;

    localparam int NPTS   = 8;
    localparam int CODE_W = 7;
    localparam int CNT_W  = 16;
    localparam int CFG_W  = 8;
    localparam int THR_W  = 6;
    localparam int PER    = 10;
    localparam int C_STEP = ((1 << CODE_W) - 1) / (NPTS - 1);
    localparam int TOTAL  = NPTS * 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst, ref_tick, vco_edge, pfd_up, pfd_dn, ratio_req;
    logic [CFG_W-1:0]  settle_refs, win_refs, lock_refs;
    logic [THR_W-1:0]  pulse_thr;
    logic              loop_closed, bias_mid, tbl_we, cal_done, ls;
    logic [2:0]        p_code;
    logic [CODE_W-1:0] c_code;
    logic [4:0]        tbl_addr;
    logic [CNT_W-1:0]  tbl_data;

    pll_cal_sequencer u_dut (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .vco_edge(vco_edge),
        .pfd_up(pfd_up), .pfd_dn(pfd_dn), .ratio_req(ratio_req),
        .settle_refs(settle_refs), .win_refs(win_refs), .lock_refs(lock_refs),
        .pulse_thr(pulse_thr), .loop_closed(loop_closed), .bias_mid(bias_mid),
        .p_code(p_code), .c_code(c_code), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_data(tbl_data), .cal_done(cal_done), .ls(ls)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int wr_count, done_count, cur_win;
    bit done_seen;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic sample_outputs();
        if (tbl_we) begin
            int pi, pt, exp_cnt;
            pi      = wr_count / NPTS;
            pt      = wr_count % NPTS;
            exp_cnt = cur_win * (1 + (pt + pi) % 9);
            check(tbl_addr == 5'(wr_count), "R3 table address", tbl_addr, wr_count);
            check(tbl_data == CNT_W'(exp_cnt), "R4 measured count", tbl_data, exp_cnt);
            check(c_code == CODE_W'(pt * C_STEP), "R2 fine code", c_code, pt * C_STEP);
            check(p_code == 3'((1 << pi) - 1), "R2 band code", p_code, (1 << pi) - 1);
            check(ls && bias_mid && !loop_closed, "R6 ls/bias/loop during sweep",
                  {ls, bias_mid, loop_closed}, 3'b110);
            wr_count++;
        end
        if (cal_done) begin
            done_count++;
            done_seen = 1'b1;
            check(loop_closed && !bias_mid, "R5 loop closed at done", {loop_closed, bias_mid}, 2'b10);
            check(wr_count == TOTAL, "R2 writes before done", wr_count, TOTAL);
        end
    endtask

    // One reference period: tick in phase 0, edge density from the current codes
    task automatic run_period(input int up_w, input int dn_w);
        int d;
        d = 1;
        for (int ph = 0; ph < PER; ph++) begin
            @(negedge clk);
            sample_outputs();
            if (ph == 0) d = 1 + (int'(c_code) / C_STEP + $countones(p_code)) % 9;
            ref_tick = (ph == 0);
            vco_edge = (ph >= 1) && (ph <= d);
            pfd_up   = (ph >= 1) && (ph <= up_w);
            pfd_dn   = (ph >= 1) && (ph <= dn_w);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ref_tick = 0; vco_edge = 0; pfd_up = 0; pfd_dn = 0; ratio_req = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!loop_closed && bias_mid && ls, "R1 reset loop/bias/ls", {loop_closed, bias_mid, ls}, 3'b011);
        check(!cal_done && !tbl_we, "R1 reset strobes", {cal_done, tbl_we}, 0);
        check(p_code == 0 && c_code == 0, "R1 reset codes", {p_code, c_code}, 0);
    endtask

    task automatic run_calibration(input int settle, input int win);
        int guard;
        settle_refs = CFG_W'(settle);
        win_refs    = CFG_W'(win);
        cur_win     = (win == 0) ? 1 : win;
        wr_count = 0; done_count = 0; done_seen = 1'b0; guard = 0;
        while (!done_seen && guard < 600) begin
            run_period(0, 0);
            guard++;
        end
        check(done_seen, "R5 calibration completes", done_seen, 1);
        check(wr_count == TOTAL, "R2 point count", wr_count, TOTAL);
    endtask

    task automatic test_lock_search();
        // R7: three good periods, then one with a wide pulse, then four good ones
        run_period(0, 0);
        run_period(0, 0);
        run_period(3, 0);
        check(ls == 1'b1, "R7 still settling after 3 periods", ls, 1);
        run_period(2, 2);
        check(ls == 1'b1, "R7 wide pulse restarts the run", ls, 1);
        run_period(2, 2);
        run_period(2, 2);
        run_period(0, 0);
        check(ls == 1'b1, "R7 narrow pulses, 3 good periods", ls, 1);
        run_period(0, 0);
        check(ls == 1'b0, "R7 lock after 4 good periods", ls, 0);
        // R8: wide pulses after lock are ignored
        run_period(5, 5);
        run_period(0, 6);
        run_period(0, 0);
        check(ls == 1'b0, "R8 ls stays low", ls, 0);
        check(done_count == 1, "R5 single done pulse", done_count, 1);
        check(loop_closed && !bias_mid, "R5 loop stays closed", {loop_closed, bias_mid}, 2'b10);
    endtask

    task automatic test_ratio_request();
        @(negedge clk);
        ratio_req = 1'b1;
        @(negedge clk);
        ratio_req = 1'b0;
        check(ls == 1'b1, "R9 ls raised by ratio request", ls, 1);
        run_period(0, 0);
        run_period(0, 0);
        run_period(0, 0);
        check(ls == 1'b1, "R9 count restarted from zero", ls, 1);
        run_period(0, 0);
        check(ls == 1'b0, "R9 relock after 4 periods", ls, 0);
    endtask

    initial begin
        rst = 1'b1; ref_tick = 0; vco_edge = 0; pfd_up = 0; pfd_dn = 0; ratio_req = 0;
        settle_refs = 8'd2; win_refs = 8'd4; lock_refs = 8'd4; pulse_thr = 6'd3;
        do_reset();
        run_calibration(2, 4);
        test_lock_search();
        test_ratio_request();
        do_reset();                     // R10: reset during operation
        run_calibration(0, 3);          // R4: zero settle acts as one
        check(loop_closed == 1'b1, "R10 second sweep closes loop", loop_closed, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule